// File: doc/BRIEF.md
# EDO DRAM Host Memory Controller

This block sits between an on-chip requester and a 1M x 16 extended-data-out DRAM. Requests come in on a valid/ready port: a 20-bit word address, a write flag, two byte enables and 16 bits of write data. The controller multiplexes each address onto the 10 DRAM address pins as a row and then a column. It sequences the row strobe, the two column strobes, write enable and output enable from clock-cycle counters. Read data is returned on a second valid/ready port.

After an access the row stays open. A later request to the same row is served by toggling only the column strobes, with the row strobe held low. A request to any other row first precharges, then opens the new row. A free-running timer raises a refresh demand at a fixed interval. The refresh takes priority over requests: the controller closes any open row and runs a column-before-row refresh, so no refresh address has to be generated.

Back-pressure rules: a request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while a strobe cycle is in progress, while a refresh is pending, and while a read response has not yet been taken. A read response stays valid, with stable data, until a clock edge where `rsp_ready` is high.

Top module: `edo_ctrl`

## Requirements
- R1: `req_ready` is high only when no strobe cycle is running, no refresh is pending and no read response is outstanding; in those states both column strobes are high.
- R2: Address bits [19:10] are driven on the address pins when the row strobe falls, and bits [9:0] are driven when a column strobe falls.
- R3: Byte enable bit 0 drives the lower column strobe (data bits [7:0]) and bit 1 drives the upper column strobe (bits [15:8]); only enabled lanes are written; a lone column strobe is never low while the row strobe is high.
- R4: A write drives write enable low at least one cycle before a column strobe falls, keeps output enable high, and drives the data pins.
- R5: A read keeps write enable high and drives output enable low; `rsp_rdata` carries the enabled lanes and zero on disabled lanes.
- R6: A request to the open row activates no new row: the row strobe stays low and only the column strobes toggle.
- R7: A request to a different row raises the row strobe for `T_RP` cycles, then activates the new row exactly once.
- R8: A refresh demand is raised every `REF_INTERVAL` clock cycles and stays raised until the controller takes it; with the controller idle, refreshes start exactly `REF_INTERVAL` cycles apart.
- R9: A refresh lowers both column strobes at least one cycle before the row strobe falls, closes any open row first, and takes priority over waiting requests.
- R10: A read response held while `rsp_ready` is low keeps `rsp_valid` high and `rsp_rdata` stable, and no new request is accepted.
- R11: During and right after reset the row strobe, both column strobes, write enable and output enable are high, the data pins are not driven and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address: row [19:10], column [9:0] |
| req_be | input | 2 | Byte enables: bit 0 lower lane, bit 1 upper lane |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 10 | Multiplexed DRAM address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_lo_n | output | 1 | Lower byte column strobe, active low |
| mem_cas_hi_n | output | 1 | Upper byte column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 16 | Data toward DRAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from DRAM |

## Verification
The main function is tried with word writes and reads, single-lane writes that merge into one word, and single-lane reads against a DRAM model that puts junk on unstrobed lanes. Together these separate correct lane steering from swapped or unmasked lanes. Accesses alternate between page hits in one row, misses across rows, and the extreme addresses 0x003FF, 0x00400 and 0xFFFFF. Counting row activations tells page mode apart from needless precharges, and the latched row and column show whether the address split is swapped. A stream of page hits running across a refresh boundary, and a read whose response is held back, expose faults in refresh priority and in back-pressure.

// File: rtl/edo_ctrl_pkg.sv
package edo_ctrl_pkg;

  // Sequencer states. Strobe levels are decoded from these.
  typedef enum logic [3:0] {
    ST_IDLE,    // no row open, RAS high
    ST_ACT,     // row address out, RAS low, wait RAS-to-CAS
    ST_CSET,    // page hit: column address setup, CAS high
    ST_COL,     // column strobes low
    ST_OPEN,    // row held open, CAS high
    ST_PRE,     // RAS high precharge
    ST_RF_CAS,  // refresh: CAS low ahead of RAS
    ST_RF_RAS,  // refresh: RAS and CAS low
    ST_RF_PRE   // refresh: all strobes high
  } seq_state_t;

endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int INTERVAL = 1562
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  output logic ref_pend
);
  localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] tick_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_cnt <= '0;
      ref_pend <= 1'b0;
    end else begin
      if (tick_cnt == LAST) tick_cnt <= '0;
      else                  tick_cnt <= tick_cnt + 1'b1;
      if (tick_cnt == LAST) ref_pend <= 1'b1;
      else if (ref_ack)     ref_pend <= 1'b0;
    end
  end

  // R8
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pend && !ref_ack) |=> ref_pend);

endmodule

// File: rtl/edo_read_path.sv
module edo_read_path #(
  parameter int DATA_W = 16,
  parameter int BE_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [BE_W-1:0]   cap_be,
  input  logic [DATA_W-1:0] dq_in,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  localparam int LANE_W = DATA_W / BE_W;

  logic [DATA_W-1:0] lane_data;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign lane_data[g*LANE_W +: LANE_W] = cap_be[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (cap_en) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= lane_data;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_ctrl_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 10,
  parameter int DATA_W    = 16,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 3,
  parameter int T_RP      = 3,
  parameter int T_CSR     = 1,
  parameter int T_RAS_REF = 4,
  parameter int CAP_DLY   = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [1:0]             req_be,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic                   rsp_busy,
  input  logic                   ref_pend,
  output logic                   ref_ack,
  output logic                   cap_en,
  output logic [1:0]             cap_be,
  output logic [ROW_W-1:0]       mem_addr,
  output logic                   mem_ras_n,
  output logic                   mem_cas_lo_n,
  output logic                   mem_cas_hi_n,
  output logic                   mem_we_n,
  output logic                   mem_oe_n,
  output logic [DATA_W-1:0]      mem_dq_out,
  output logic                   mem_dq_oe
);
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int CNT_W  = $clog2(T_RCD + T_CAS + T_RP + T_CSR + T_RAS_REF + 2);
  localparam logic [CNT_W-1:0] L_RCD = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] L_CAS = CNT_W'(T_CAS - 1);
  localparam logic [CNT_W-1:0] L_RP  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] L_CSR = CNT_W'(T_CSR - 1);
  localparam logic [CNT_W-1:0] L_REF = CNT_W'(T_RAS_REF - 1);
  localparam logic [CNT_W-1:0] L_CAP = CNT_W'(CAP_DLY);

  seq_state_t state, nxt;
  logic [CNT_W-1:0]  cnt;
  logic              q_wr;
  logic [ROW_W-1:0]  q_row, open_row;
  logic [COL_W-1:0]  q_col;
  logic [1:0]        q_be;
  logic [DATA_W-1:0] q_wd;
  logic              pre_to_act;
  logic              accept, hit, done;

  assign req_ready = ((state == ST_IDLE) || (state == ST_OPEN)) && !ref_pend && !rsp_busy;
  assign accept    = req_valid && req_ready;
  assign hit       = (req_addr[ADDR_W-1:COL_W] == open_row);

  always_comb begin
    unique case (state)
      ST_ACT:    done = (cnt == L_RCD);
      ST_COL:    done = (cnt == L_CAS);
      ST_PRE:    done = (cnt == L_RP);
      ST_RF_CAS: done = (cnt == L_CSR);
      ST_RF_RAS: done = (cnt == L_REF);
      ST_RF_PRE: done = (cnt == L_RP);
      default:   done = 1'b1;
    endcase
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (ref_pend)    nxt = ST_RF_CAS;
        else if (accept) nxt = ST_ACT;
      end
      ST_ACT:  if (done) nxt = ST_COL;
      ST_CSET: nxt = ST_COL;
      ST_COL:  if (done) nxt = ST_OPEN;
      ST_OPEN: begin
        if (ref_pend)    nxt = ST_PRE;
        else if (accept) nxt = hit ? ST_CSET : ST_PRE;
      end
      ST_PRE:    if (done) nxt = pre_to_act ? ST_ACT : ST_RF_CAS;
      ST_RF_CAS: if (done) nxt = ST_RF_RAS;
      ST_RF_RAS: if (done) nxt = ST_RF_PRE;
      ST_RF_PRE: if (done) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      q_wr       <= 1'b0;
      q_row      <= '0;
      q_col      <= '0;
      q_be       <= '0;
      q_wd       <= '0;
      open_row   <= '0;
      pre_to_act <= 1'b0;
    end else begin
      state <= nxt;
      cnt   <= (nxt != state) ? '0 : cnt + 1'b1;
      if (accept) begin
        q_wr  <= req_write;
        q_row <= req_addr[ADDR_W-1:COL_W];
        q_col <= req_addr[COL_W-1:0];
        q_be  <= req_be;
        q_wd  <= req_wdata;
      end
      if (state == ST_OPEN) begin
        if (ref_pend)              pre_to_act <= 1'b0;
        else if (accept && !hit)   pre_to_act <= 1'b1;
      end
      if ((state == ST_COL) && done) open_row <= q_row;
    end
  end

  // Strobe and pin decode
  logic in_col, in_ref_cas, row_low, wr_phase;
  assign in_col     = (state == ST_COL);
  assign in_ref_cas = (state == ST_RF_CAS) || (state == ST_RF_RAS);
  assign row_low    = (state == ST_ACT) || (state == ST_CSET) || in_col ||
                      (state == ST_OPEN) || (state == ST_RF_RAS);
  assign wr_phase   = q_wr && ((state == ST_ACT) || (state == ST_CSET) || in_col);

  assign mem_ras_n    = !row_low;
  assign mem_cas_lo_n = !((in_col && q_be[0]) || in_ref_cas);
  assign mem_cas_hi_n = !((in_col && q_be[1]) || in_ref_cas);
  assign mem_we_n     = !wr_phase;
  assign mem_oe_n     = !(in_col && !q_wr);
  assign mem_dq_oe    = wr_phase;
  assign mem_dq_out   = q_wd;

  always_comb begin
    if (state == ST_ACT)                          mem_addr = q_row;
    else if ((state == ST_CSET) || in_col)        mem_addr = ROW_W'(q_col);
    else                                          mem_addr = '0;
  end

  assign ref_ack = (state == ST_RF_CAS) && (cnt == '0);
  assign cap_en  = in_col && !q_wr && (cnt == L_CAP);
  assign cap_be  = q_be;

  // R9
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ras_n) && !mem_cas_lo_n) |-> $past(!mem_cas_lo_n));

  // R4
  early_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(mem_cas_lo_n) || $fell(mem_cas_hi_n)) && !mem_we_n) |-> $past(!mem_we_n));

  // R4
  wr_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  // R3
  lane_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cas_lo_n != mem_cas_hi_n) |-> !mem_ras_n);

  // R1
  ready_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cas_lo_n && mem_cas_hi_n));

endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl #(
  parameter int ROW_W        = 10,
  parameter int COL_W        = 10,
  parameter int DATA_W       = 16,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 3,
  parameter int T_RP         = 3,
  parameter int T_CSR        = 1,
  parameter int T_RAS_REF    = 4,
  parameter int CAP_DLY      = 1,
  parameter int REF_INTERVAL = 1562
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [1:0]             req_be,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic [ROW_W-1:0]       mem_addr,
  output logic                   mem_ras_n,
  output logic                   mem_cas_lo_n,
  output logic                   mem_cas_hi_n,
  output logic                   mem_we_n,
  output logic                   mem_oe_n,
  output logic [DATA_W-1:0]      mem_dq_out,
  output logic                   mem_dq_oe,
  input  logic [DATA_W-1:0]      mem_dq_in
);
  localparam int BE_W = 2;

  logic          ref_pend, ref_ack, cap_en;
  logic [BE_W-1:0] cap_be;

  edo_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_pend(ref_pend)
  );

  edo_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_RP(T_RP), .T_CSR(T_CSR), .T_RAS_REF(T_RAS_REF), .CAP_DLY(CAP_DLY)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_busy(rsp_valid), .ref_pend(ref_pend), .ref_ack(ref_ack),
    .cap_en(cap_en), .cap_be(cap_be),
    .mem_addr(mem_addr), .mem_ras_n(mem_ras_n),
    .mem_cas_lo_n(mem_cas_lo_n), .mem_cas_hi_n(mem_cas_hi_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
  );

  edo_read_path #(.DATA_W(DATA_W), .BE_W(BE_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_be(cap_be),
    .dq_in(mem_dq_in), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

endmodule

// File: tb/edo_ctrl_tb_top.sv
module edo_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int REF_INT    = 400;
  localparam int T_RP_TB    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic [9:0]  mem_addr;
  logic        mem_ras_n, mem_cas_lo_n, mem_cas_hi_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [15:0] mem_dq_out;
  logic [15:0] mem_dq_in = 16'hEEEE;

  always #(CLK_PERIOD/2) clk = ~clk;

  edo_ctrl #(.T_RCD(2), .T_CAS(3), .T_RP(T_RP_TB), .T_CSR(1), .T_RAS_REF(3),
             .CAP_DLY(1), .REF_INTERVAL(REF_INT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_lo_n(mem_cas_lo_n),
    .mem_cas_hi_n(mem_cas_hi_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // ---------------- DRAM model, sampled at the falling clock edge ----------------
  logic [15:0] mem_m [logic [19:0]];
  int cyc = 0, act_cnt = 0, ref_cnt = 0, order_err = 0, we_err = 0, rp_err = 0;
  int ref_prev = 0, ref_last = 0, ras_hi_len = 0;
  logic [9:0] m_row = '0, m_col = '0;
  logic p_ras = 1'b1, p_lo = 1'b1, p_hi = 1'b1, p_we = 1'b1;

  always @(negedge clk) begin
    logic [19:0] a;
    logic [15:0] w;
    cyc++;
    if (rst_n) begin
      if (p_ras && !mem_ras_n) begin
        if (!mem_cas_lo_n || !mem_cas_hi_n) begin
          ref_cnt++;
          ref_prev = ref_last;
          ref_last = cyc;
          if (p_lo || p_hi) order_err++;
        end else begin
          act_cnt++;
          m_row = mem_addr;
          if (ras_hi_len < T_RP_TB) rp_err++;
        end
      end
      if (!mem_ras_n && ((p_lo && !mem_cas_lo_n) || (p_hi && !mem_cas_hi_n))) begin
        m_col = mem_addr;
        a = {m_row, m_col};
        if (!mem_we_n) begin
          if (p_we || !mem_dq_oe) we_err++;
          w = mem_m.exists(a) ? mem_m[a] : 16'h0000;
          if (!mem_cas_lo_n) w[7:0]  = mem_dq_out[7:0];
          if (!mem_cas_hi_n) w[15:8] = mem_dq_out[15:8];
          mem_m[a] = w;
        end
      end
      if (!mem_ras_n && !mem_oe_n) begin
        a = {m_row, m_col};
        w = mem_m.exists(a) ? mem_m[a] : 16'h0000;
        mem_dq_in = {(!mem_cas_hi_n ? w[15:8] : 8'hEE), (!mem_cas_lo_n ? w[7:0] : 8'hEE)};
      end else begin
        mem_dq_in = 16'hEEEE;
      end
    end
    ras_hi_len = mem_ras_n ? ras_hi_len + 1 : 0;
    p_ras = mem_ras_n; p_lo = mem_cas_lo_n; p_hi = mem_cas_hi_n; p_we = mem_we_n;
  end

  // ---------------- checking ----------------
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic wr, input logic [19:0] addr, input logic [1:0] be,
                        input logic [15:0] wd, output logic [15:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_be = be; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = '0;
    if (!wr) begin
      while (!rsp_valid) @(negedge clk);
      rd = rsp_rdata;
    end
    while (!req_ready) @(negedge clk);
  endtask

  typedef struct packed {
    logic        wr;
    logic [19:0] addr;
    logic [1:0]  be;
    logic [15:0] data;   // write data, or expected read data
    logic        act;    // expected number of new row activations
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 20'h00005, 2'b11, 16'hA1B2, 1'b1},  // R3 word write, opens row 0
    '{1'b0, 20'h00005, 2'b11, 16'hA1B2, 1'b0},  // R6 page hit read
    '{1'b1, 20'h00006, 2'b01, 16'hFF33, 1'b0},  // R3 lower lane write
    '{1'b0, 20'h00006, 2'b11, 16'h0033, 1'b0},  // R3 upper untouched
    '{1'b1, 20'h00006, 2'b10, 16'h7744, 1'b0},  // R3 upper lane write
    '{1'b0, 20'h00006, 2'b01, 16'h0033, 1'b0},  // R5 upper masked
    '{1'b0, 20'h00006, 2'b10, 16'h7700, 1'b0},  // R5 lower masked
    '{1'b1, 20'h2A3C5, 2'b11, 16'h1234, 1'b1},  // R7 miss
    '{1'b0, 20'h00005, 2'b11, 16'hA1B2, 1'b1},  // R7 miss back
    '{1'b0, 20'h2A3C5, 2'b11, 16'h1234, 1'b1},  // R2 split
    '{1'b1, 20'hFFFFF, 2'b11, 16'hCAFE, 1'b1},  // R2 top row and column
    '{1'b0, 20'hFFFFF, 2'b11, 16'hCAFE, 1'b0},  // R6
    '{1'b0, 20'h003FF, 2'b11, 16'h0000, 1'b1},  // R2 last column of row 0
    '{1'b1, 20'h00400, 2'b11, 16'h0F0F, 1'b1},  // R2 first column of row 1
    '{1'b0, 20'h00400, 2'b11, 16'h0F0F, 1'b0}   // R6
  };

  initial begin
    logic [15:0] rd;
    int a0, r0, held_bad;
    // R11 reset state
    repeat (4) @(negedge clk);
    chk("R11 strobes in reset", {mem_ras_n, mem_cas_lo_n, mem_cas_hi_n, mem_we_n, mem_oe_n}, 5'b11111);
    chk("R11 dq/rsp in reset", {mem_dq_oe, rsp_valid}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 strobes after reset", {mem_ras_n, mem_cas_lo_n, mem_cas_hi_n, mem_we_n, mem_oe_n}, 5'b11111);
    chk("R1 ready after reset", req_ready, 1'b1);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      a0 = act_cnt;
      do_req(VECS[i].wr, VECS[i].addr, VECS[i].be, VECS[i].data, rd);
      chk($sformatf("R6/R7 activations v%0d", i), act_cnt - a0, {31'd0, VECS[i].act});
      chk($sformatf("R2 row v%0d", i), m_row, VECS[i].addr[19:10]);
      chk($sformatf("R2 col v%0d", i), m_col, VECS[i].addr[9:0]);
      if (!VECS[i].wr) chk($sformatf("R5 read data v%0d", i), rd, VECS[i].data);
    end
    chk("R4 early write and data drive", we_err, 0);
    chk("R7 precharge length", rp_err, 0);

    // R8 refresh spacing with the controller idle
    while (ref_cnt < 3) @(negedge clk);
    chk("R8 refresh spacing", ref_last - ref_prev, REF_INT);
    chk("R9 CAS before RAS order", order_err, 0);

    // R10 back-pressure on a held read response
    do_req(1'b0, 20'h00005, 2'b11, 16'h0, rd);
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h00005; req_be = 2'b11;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    held_bad = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (!rsp_valid || rsp_rdata !== rd || req_ready) held_bad++;
    end
    chk("R10 response held", held_bad, 0);
    chk("R1 no accept while response pending", req_ready, 1'b0);
    chk("R10 held data", rd, 16'hA1B2);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10 response taken", rsp_valid, 1'b0);

    // R9 refresh priority across a stream of page hits
    while (!req_ready) @(negedge clk);
    a0 = act_cnt; r0 = ref_cnt;
    held_bad = 0;
    while (ref_cnt == r0) begin
      do_req(1'b0, 20'h00005, 2'b11, 16'h0, rd);
      if (rd !== 16'hA1B2) held_bad++;
    end
    for (int k = 0; k < 2; k++) begin
      do_req(1'b0, 20'h00005, 2'b11, 16'h0, rd);
      if (rd !== 16'hA1B2) held_bad++;
    end
    chk("R9 data across refresh", held_bad, 0);
    chk("R9 row reopened once after refresh", act_cnt - a0, 1);
    chk("R9 CAS before RAS order final", order_err, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule